// File: doc/BRIEF.md
# Display Access Slot Timer

This block produces the horizontal and vertical timing skeleton for a tile-based video processor. It counts master clocks across each line and splits the line into memory access slots. The slot length depends on the horizontal resolution mode. Each slot is announced with a one-clock strobe and its index. A few fixed slot indices per mode are reserved for memory refresh. Every other slot is offered to the external (host) port whenever the display is blanked or the line lies outside the visible area.

The resolution mode and the video standard are sampled once per frame, on the first clock of line 0, so that a host write in mid-frame cannot bend the geometry of the frame in progress. While the display is switched off on visible lines, the block also issues background-fill strobes. Each strobe carries a pixel offset for a 16-pixel write. All outputs are registered, so each one reflects the counter state of the previous clock together with the display-enable level sampled at that edge.

Top module: `vst_slot_timer`

## Requirements
- R1: While `rst` is high, every output is driven to zero.
- R2: A line is `LINE_CLKS` (default 3420) master clocks long. `slot_stb` is high on the first clock of every slot. `slot_idx` holds the slot number for the whole slot, counts up by one per slot, and restarts at 0 on the first clock of each line.
- R3: A slot lasts 16 clocks in wide mode and 20 clocks in narrow mode. In wide mode the last slot of a line is cut short at the line boundary (slot 213, 12 clocks).
- R4: In wide mode, `refresh` pulses with `slot_stb` exactly on slots 73, 105, 137, 169 and 201.
- R5: In narrow mode, `refresh` pulses with `slot_stb` exactly on slots 66, 98, 130 and 162.
- R6: `ext_en` pulses with `slot_stb` on every non-refresh slot when `disp_en` is low or `line_active` is low. It is never high on a refresh slot, and never high while `disp_en` is high on an active line.
- R7: `line_num` advances by one at each line boundary and wraps from `FRAME_LINES`-1 to 0.
- R8: `line_active` is high when `line_num` is below the active count: 225 lines (`ACTIVE_NTSC`) with the latched standard bit low, and 241 lines (`ACTIVE_PAL`) with it high.
- R9: `wide_in` and `pal_in` are captured on the first clock of line 0 only. Changes at any other time take effect at the next frame. `wide_q` shows the captured wide bit (1 = wide).
- R10: With `disp_en` low on lines 1 up to the last active line, `fill_stb` pulses on slots 55 to 207 in steps of 8 (wide) or 48 to 168 in steps of 8 (narrow). `fill_x` then equals twice the slot offset from the first fill slot, rounded down to a multiple of 16. Otherwise `fill_x` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_in | input | 1 | Requested horizontal mode, 1 = wide (40-cell) |
| pal_in | input | 1 | Requested standard, 1 = 50 Hz (more active lines) |
| disp_en | input | 1 | Display enable; low blanks the picture |
| slot_stb | output | 1 | First clock of a slot |
| slot_idx | output | SLOT_W | Index of the current slot in the line |
| refresh | output | 1 | Current slot is a refresh slot (with strobe) |
| ext_en | output | 1 | Current slot is granted to external access (with strobe) |
| line_num | output | LINE_W | Current line in the frame |
| line_active | output | 1 | Current line is in the visible area |
| wide_q | output | 1 | Latched horizontal mode for this frame |
| fill_stb | output | 1 | Background fill write for this slot |
| fill_x | output | SLOT_W+1 | Pixel offset of the 16-pixel fill write |

## Verification
The assertions assume that the slot period parameters are no longer than the line and that the narrow period is at least the wide one. Only the very first strobe after reset and each line's slot 0 are exempt from the period and step checks. They place no demands on the mode or enable inputs, which may change on any clock. The stimulus relies on this: it flips `wide_in` and `pal_in` in mid-frame and toggles `disp_en` between lines. The bench runs a shortened frame, so three whole frames cover every slot of every line in both modes and both standards.

// File: rtl/vst_pkg.sv
package vst_pkg;

  // Mode bits captured once per frame.
  typedef struct packed {
    logic wide;  // 1: short slots, more cells per line
    logic pal;   // 1: taller visible area
  } vst_mode_t;

endpackage

// File: rtl/vst_line_counter.sv
module vst_line_counter
  import vst_pkg::*;
#(
  parameter int LINE_CLKS        = 3420,
  parameter int WIDE_SLOT_CLKS   = 16,
  parameter int NARROW_SLOT_CLKS = 20,
  parameter int FRAME_LINES      = 262,
  parameter int SLOT_W           = 8,
  parameter int LINE_W           = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  vst_mode_t         mode_in,
  output logic              slot_first,
  output logic [SLOT_W-1:0] slot,
  output logic [LINE_W-1:0] line,
  output vst_mode_t         mode_q
);

  localparam int CLK_W = $clog2(LINE_CLKS);
  localparam int SUB_W = $clog2(NARROW_SLOT_CLKS);

  localparam logic [CLK_W-1:0]  CLK_LAST    = CLK_W'(LINE_CLKS - 1);
  localparam logic [SUB_W-1:0]  WIDE_LAST   = SUB_W'(WIDE_SLOT_CLKS - 1);
  localparam logic [SUB_W-1:0]  NARROW_LAST = SUB_W'(NARROW_SLOT_CLKS - 1);
  localparam logic [LINE_W-1:0] LINE_LAST   = LINE_W'(FRAME_LINES - 1);

  logic [CLK_W-1:0] clk_pos;
  logic [SUB_W-1:0] sub_pos;
  logic [SUB_W-1:0] sub_last;
  logic             line_end;
  logic             frame_start;

  assign sub_last    = mode_q.wide ? WIDE_LAST : NARROW_LAST;
  assign line_end    = (clk_pos == CLK_LAST);
  assign frame_start = (line == '0) && (clk_pos == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_pos <= '0;
      sub_pos <= '0;
      slot    <= '0;
      line    <= '0;
    end else if (line_end) begin
      clk_pos <= '0;
      sub_pos <= '0;
      slot    <= '0;
      line    <= (line == LINE_LAST) ? '0 : line + 1'b1;
    end else begin
      clk_pos <= clk_pos + 1'b1;
      if (sub_pos == sub_last) begin
        sub_pos <= '0;
        slot    <= slot + 1'b1;
      end else begin
        sub_pos <= sub_pos + 1'b1;
      end
    end
  end

  // Mode capture: first clock of the frame only.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (frame_start) begin
      mode_q <= mode_in;
    end
  end

  assign slot_first = (sub_pos == '0);

endmodule

// File: rtl/vst_refresh_match.sv
module vst_refresh_match #(
  parameter int SLOT_W = 8,
  parameter int FIRST  = 73,
  parameter int STEP   = 32,
  parameter int COUNT  = 5
) (
  input  logic [SLOT_W-1:0] slot,
  output logic              hit
);

  logic [COUNT-1:0] eq;

  for (genvar i = 0; i < COUNT; i++) begin : g_idx
    localparam logic [SLOT_W-1:0] IDX = SLOT_W'(FIRST + i * STEP);
    assign eq[i] = (slot == IDX);
  end

  assign hit = |eq;

endmodule

// File: rtl/vst_fill_match.sv
module vst_fill_match #(
  parameter int SLOT_W = 8,
  parameter int START  = 55,
  parameter int STOP   = 207,
  parameter int STEP   = 8,
  parameter int SPAN   = 16
) (
  input  logic [SLOT_W-1:0] slot,
  output logic              hit,
  output logic [SLOT_W:0]   xpos
);

  localparam logic [SLOT_W-1:0] START_T   = SLOT_W'(START);
  localparam logic [SLOT_W-1:0] STOP_T    = SLOT_W'(STOP);
  localparam logic [SLOT_W-1:0] STEP_MASK = SLOT_W'(STEP - 1);
  localparam logic [SLOT_W-1:0] SPAN_MASK = SLOT_W'(SPAN - 1);

  logic [SLOT_W-1:0] diff;

  assign diff = slot - START_T;
  assign hit  = (slot >= START_T) && (slot <= STOP_T) && ((diff & STEP_MASK) == '0);
  assign xpos = {diff & ~SPAN_MASK, 1'b0};

endmodule

// File: rtl/vst_slot_timer.sv
module vst_slot_timer
  import vst_pkg::*;
#(
  parameter int LINE_CLKS        = 3420,
  parameter int WIDE_SLOT_CLKS   = 16,
  parameter int NARROW_SLOT_CLKS = 20,
  parameter int FRAME_LINES      = 262,
  parameter int ACTIVE_NTSC      = 225,
  parameter int ACTIVE_PAL       = 241,
  parameter int WIDE_REF_FIRST   = 73,
  parameter int WIDE_REF_COUNT   = 5,
  parameter int NARROW_REF_FIRST = 66,
  parameter int NARROW_REF_COUNT = 4,
  parameter int REF_STEP         = 32,
  parameter int WIDE_FILL_START  = 55,
  parameter int WIDE_FILL_STOP   = 207,
  parameter int NARROW_FILL_START = 48,
  parameter int NARROW_FILL_STOP = 168,
  parameter int FILL_STEP        = 8,
  parameter int FILL_SPAN        = 16,
  localparam int SLOT_W = $clog2((LINE_CLKS + WIDE_SLOT_CLKS - 1) / WIDE_SLOT_CLKS),
  localparam int LINE_W = $clog2(FRAME_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_in,
  input  logic              pal_in,
  input  logic              disp_en,
  output logic              slot_stb,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              refresh,
  output logic              ext_en,
  output logic [LINE_W-1:0] line_num,
  output logic              line_active,
  output logic              wide_q,
  output logic              fill_stb,
  output logic [SLOT_W:0]   fill_x
);

  vst_mode_t         mode_in;
  vst_mode_t         mode_q;
  logic              slot_first;
  logic [SLOT_W-1:0] slot;
  logic [LINE_W-1:0] line;

  assign mode_in = '{wide: wide_in, pal: pal_in};

  vst_line_counter #(
    .LINE_CLKS        (LINE_CLKS),
    .WIDE_SLOT_CLKS   (WIDE_SLOT_CLKS),
    .NARROW_SLOT_CLKS (NARROW_SLOT_CLKS),
    .FRAME_LINES      (FRAME_LINES),
    .SLOT_W           (SLOT_W),
    .LINE_W           (LINE_W)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .mode_in    (mode_in),
    .slot_first (slot_first),
    .slot       (slot),
    .line       (line),
    .mode_q     (mode_q)
  );

  // One decoder pair per horizontal mode; the latched bit picks one.
  logic [1:0]        ref_hit;
  logic [1:0]        fill_hit;
  logic [SLOT_W:0]   fill_pos [2];

  for (genvar m = 0; m < 2; m++) begin : g_mode
    localparam bit IS_WIDE = (m == 1);
    vst_refresh_match #(
      .SLOT_W (SLOT_W),
      .FIRST  (IS_WIDE ? WIDE_REF_FIRST : NARROW_REF_FIRST),
      .STEP   (REF_STEP),
      .COUNT  (IS_WIDE ? WIDE_REF_COUNT : NARROW_REF_COUNT)
    ) u_ref (
      .slot (slot),
      .hit  (ref_hit[m])
    );
    vst_fill_match #(
      .SLOT_W (SLOT_W),
      .START  (IS_WIDE ? WIDE_FILL_START : NARROW_FILL_START),
      .STOP   (IS_WIDE ? WIDE_FILL_STOP : NARROW_FILL_STOP),
      .STEP   (FILL_STEP),
      .SPAN   (FILL_SPAN)
    ) u_fill (
      .slot (slot),
      .hit  (fill_hit[m]),
      .xpos (fill_pos[m])
    );
  end

  logic            is_ref;
  logic            is_fill_slot;
  logic            in_view;
  logic            fill_now;
  logic [SLOT_W:0] fill_off;

  assign is_ref       = mode_q.wide ? ref_hit[1] : ref_hit[0];
  assign is_fill_slot = mode_q.wide ? fill_hit[1] : fill_hit[0];
  assign fill_off     = mode_q.wide ? fill_pos[1] : fill_pos[0];
  assign in_view      = mode_q.pal ? (32'(line) < 32'(ACTIVE_PAL))
                                   : (32'(line) < 32'(ACTIVE_NTSC));
  assign fill_now     = slot_first && is_fill_slot && in_view
                        && (line != '0) && !disp_en;

  // Registered output stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_stb    <= 1'b0;
      slot_idx    <= '0;
      refresh     <= 1'b0;
      ext_en      <= 1'b0;
      line_num    <= '0;
      line_active <= 1'b0;
      wide_q      <= 1'b0;
      fill_stb    <= 1'b0;
      fill_x      <= '0;
    end else begin
      slot_stb    <= slot_first;
      slot_idx    <= slot;
      refresh     <= slot_first && is_ref;
      ext_en      <= slot_first && !is_ref && (!disp_en || !in_view);
      line_num    <= line;
      line_active <= in_view;
      wide_q      <= mode_q.wide;
      fill_stb    <= fill_now;
      fill_x      <= fill_now ? fill_off : '0;
    end
  end

endmodule

// File: rtl/vst_slot_timer_chk.sv
module vst_slot_timer_chk #(
  parameter int WIDE_SLOT_CLKS   = 16,
  parameter int NARROW_SLOT_CLKS = 20,
  parameter int SLOT_W           = 8,
  parameter int LINE_W           = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              slot_stb,
  input logic [SLOT_W-1:0] slot_idx,
  input logic              refresh,
  input logic              ext_en,
  input logic [LINE_W-1:0] line_num,
  input logic              line_active,
  input logic              wide_q,
  input logic              fill_stb
);

  localparam logic [7:0] WIDE_GAP   = 8'(WIDE_SLOT_CLKS);
  localparam logic [7:0] NARROW_GAP = 8'(NARROW_SLOT_CLKS);

  logic [7:0] gap;

  always_ff @(posedge clk) begin
    if (rst)                gap <= '0;
    else if (slot_stb)      gap <= 8'd1;
    else if (gap != 8'hFF)  gap <= gap + 8'd1;
  end

  AST_SLOT_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (slot_stb && slot_idx != '0) |-> (gap == (wide_q ? WIDE_GAP : NARROW_GAP))); // R3

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !slot_stb |-> $stable(slot_idx)); // R2

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (slot_stb && slot_idx != '0) |-> (slot_idx == SLOT_W'($past(slot_idx) + 1'b1))); // R2

  AST_REFRESH_ON_STB: assert property (@(posedge clk) disable iff (rst)
    refresh |-> slot_stb); // R4

  AST_EXT_NOT_REFRESH: assert property (@(posedge clk) disable iff (rst)
    ext_en |-> (slot_stb && !refresh)); // R6

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(slot_stb && slot_idx == '0) |-> $stable(line_num)); // R7

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (line_num != '0) |-> $stable(wide_q)); // R9

  AST_FILL_LINES: assert property (@(posedge clk) disable iff (rst)
    fill_stb |-> (slot_stb && line_active && line_num != '0)); // R10

endmodule

bind vst_slot_timer vst_slot_timer_chk #(
  .WIDE_SLOT_CLKS   (WIDE_SLOT_CLKS),
  .NARROW_SLOT_CLKS (NARROW_SLOT_CLKS),
  .SLOT_W           (SLOT_W),
  .LINE_W           (LINE_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .slot_stb    (slot_stb),
  .slot_idx    (slot_idx),
  .refresh     (refresh),
  .ext_en      (ext_en),
  .line_num    (line_num),
  .line_active (line_active),
  .wide_q      (wide_q),
  .fill_stb    (fill_stb)
);

// File: tb/vst_slot_timer_tb.sv
`timescale 1ns/1ps
module vst_slot_timer_tb;

  localparam int LC = 3420;
  localparam int FL = 12;
  localparam int AN = 5;
  localparam int AP = 8;
  localparam int SW = 8;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wide_in = 1'b0;
  logic pal_in = 1'b0;
  logic disp_en = 1'b0;

  logic          slot_stb, refresh, ext_en, line_active, wide_q, fill_stb;
  logic [SW-1:0] slot_idx;
  logic [LW-1:0] line_num;
  logic [SW:0]   fill_x;

  always #5 clk = ~clk;

  vst_slot_timer #(
    .FRAME_LINES (FL),
    .ACTIVE_NTSC (AN),
    .ACTIVE_PAL  (AP)
  ) u_dut (
    .clk(clk), .rst(rst), .wide_in(wide_in), .pal_in(pal_in), .disp_en(disp_en),
    .slot_stb(slot_stb), .slot_idx(slot_idx), .refresh(refresh), .ext_en(ext_en),
    .line_num(line_num), .line_active(line_active), .wide_q(wide_q),
    .fill_stb(fill_stb), .fill_x(fill_x)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  // Reference model state.
  int m_clk, m_line, per, s;
  bit m_wide, m_pal, act, rf, fw;
  int fstart, e_x;
  bit e_stb, e_ref, e_ext, e_act, e_wide, e_fill;
  int e_slot, e_line;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_clk = 0; m_line = 0; m_wide = 0; m_pal = 0;
      e_stb = 0; e_ref = 0; e_ext = 0; e_act = 0; e_wide = 0; e_fill = 0;
      e_slot = 0; e_line = 0; e_x = 0;
    end else begin
      per = m_wide ? 16 : 20;
      s = m_clk / per;
      act = m_line < (m_pal ? AP : AN);
      if (m_wide) rf = (s == 73 || s == 105 || s == 137 || s == 169 || s == 201);
      else        rf = (s == 66 || s == 98 || s == 130 || s == 162);
      fstart = m_wide ? 55 : 48;
      fw = m_wide ? (s >= 55 && s <= 207 && (s - 55) % 8 == 0)
                  : (s >= 48 && s <= 168 && (s - 48) % 8 == 0);
      e_stb  = (m_clk % per) == 0;
      e_slot = s;
      e_line = m_line;
      e_act  = act;
      e_wide = m_wide;
      e_ref  = e_stb && rf;
      e_ext  = e_stb && !rf && (!disp_en || !act);
      e_fill = e_stb && fw && act && m_line >= 1 && !disp_en;
      e_x    = e_fill ? ((s - fstart) / 16) * 32 : 0;
      if (m_line == 0 && m_clk == 0) begin
        m_wide = wide_in;
        m_pal  = pal_in;
      end
      m_clk++;
      if (m_clk == LC) begin
        m_clk = 0;
        m_line = (m_line + 1) % FL;
      end
    end
  end

  task automatic chk(input string tag, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_err++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act_v, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      if (rst) begin
        chk("R1 slot_stb", int'(slot_stb), 0);
        chk("R1 slot_idx", int'(slot_idx), 0);
        chk("R1 ext_en", int'(ext_en), 0);
        chk("R1 line_num", int'(line_num), 0);
        chk("R1 fill_stb", int'(fill_stb), 0);
      end else begin
        chk("R2 slot_stb", int'(slot_stb), int'(e_stb));
        chk("R3 slot_idx", int'(slot_idx), e_slot);
        chk(e_wide ? "R4 refresh wide" : "R5 refresh narrow", int'(refresh), int'(e_ref));
        chk("R6 ext_en", int'(ext_en), int'(e_ext));
        chk("R7 line_num", int'(line_num), e_line);
        chk("R8 line_active", int'(line_active), int'(e_act));
        chk("R9 wide_q", int'(wide_q), int'(e_wide));
        chk("R10 fill_stb", int'(fill_stb), int'(e_fill));
        chk("R10 fill_x", int'(fill_x), e_x);
      end
    end
  end

  task automatic lines(input int n);
    repeat (n * LC) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk_on = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Frame 0: narrow, short visible area, blanked then shown.
    lines(2);
    disp_en = 1'b1;
    lines(2);
    wide_in = 1'b1;              // R9: mid-frame change must wait
    pal_in  = 1'b1;
    lines(3);
    disp_en = 1'b0;
    lines(5);
    // Frame 1: wide, tall visible area.
    lines(4);
    disp_en = 1'b1;
    lines(4);
    disp_en = 1'b0;
    wide_in = 1'b0;              // next frame narrow, tall
    lines(4);
    // Frame 2: narrow, tall visible area.
    lines(3);
    disp_en = 1'b1;
    lines(3);
    disp_en = 1'b0;
    lines(6);
    repeat (60) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    wait (done || cyc >= 190000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule